// File: doc/BRIEF.md
# Auto-Reload Down-Counting Timer

This block is a down-counting timer with a configurable width of 8 or 16 bits. Software reaches it over a byte-wide register bus: one or two buffer byte addresses and a control byte. The buffer holds the reload value. A read of a buffer address returns the live count rather than the stored buffer. While the timer is stopped, a buffer write also goes straight into the counter. Setting the run bit copies the buffer into the counter and starts counting. Each step from zero reloads the buffer, so software can write the next period while the current one is still running.

The count rate comes from one of two sources. The first is a system-clock tick qualifier divided by a 3-bit prescaler. The second is an asynchronous external clock, which passes through a two-flop synchroniser and is counted on its rising edge. A step from zero sets a sticky underflow flag. An interrupt request is raised while the flag is set and the interrupt enable input is high. Software clears the flag by writing 0 to it. If hardware sets the flag in the same cycle, the set wins.

Top module: `reload_timer`

## Requirements
- R1: After reset the control byte reads 0x00, both count bytes read 0x00 and irq is low.
- R2: While running, the count drops by one on each count step.
- R3: A count step taken at zero reloads the buffer value into the counter. A buffer write made while running therefore takes effect at the next reload.
- R4: Writing 0 to the run bit stops the count, and the count then holds its value.
- R5: Writing 1 to the run bit while stopped loads the buffer into the counter and restarts the prescaler phase.
- R6: A buffer write while stopped also loads the counter. A buffer write while running leaves the count unchanged.
- R7: Address 0 reads count bits 7:0. Address 1 reads count bits 15:8, or 0x00 when the width is 8.
- R8: The prescale field selects the divider: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8 and 1xx gives 16. After a start, a step occurs on every d-th cycle in which sys_tick is high.
- R9: A step from zero sets the sticky flag (control bit 6). irq equals flag AND irq_en.
- R10: Writing the control byte with bit 6 at 0 clears the flag, but a hardware set in the same cycle wins.
- R11: With control bit 5 set, the timer takes one step per rising edge of ext_clk. The step lands on the third clock edge after ext_clk rises. sys_tick and the prescale field are then ignored.
- R12: The control byte sits at address 2 and holds run in bit 7, flag in bit 6, ext select in bit 5 and prescale in bits 2:0. Bits 4:3 read 0, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_tick | input | 1 | System-clock tick qualifier feeding the prescaler |
| ext_clk | input | 1 | Asynchronous external count clock |
| irq_en | input | 1 | Interrupt enable from the interrupt controller |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register byte address |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for bus_addr |
| irq | output | 1 | Underflow interrupt request |

## Verification
The bench writes a new buffer value while the timer runs. The old count must carry on, and the new value must appear only after the step from zero. A design that wrote through while running would shorten the current period. A clear of the flag is issued in the same cycle as an underflow, so a design that let the clear win would lose an interrupt. Divide-by-4 and divide-by-16 are measured from a start. A design that kept the prescaler phase across the start, or decoded 1xx wrongly, would show a different count. The external-clock test holds sys_tick high and sets a nonzero prescale field. A design that failed to ignore them, or that counted both edges of the external clock, would end on the wrong count.

// File: rtl/rltmr_pkg.sv
package rltmr_pkg;
  localparam int BIT_RUN  = 7;
  localparam int BIT_FLAG = 6;
  localparam int BIT_EXT  = 5;
  localparam logic [1:0] ADDR_LO  = 2'd0;
  localparam logic [1:0] ADDR_HI  = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;

  // Last prescaler phase before a step: divisor minus one.
  function automatic logic [3:0] presc_last(input logic [2:0] sel);
    if (sel[2]) return 4'd15;
    case (sel[1:0])
      2'd0:    return 4'd0;
      2'd1:    return 4'd1;
      2'd2:    return 4'd3;
      default: return 4'd7;
    endcase
  endfunction
endpackage

// File: rtl/rltmr_clkgen.sv
module rltmr_clkgen
  import rltmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_tick,
  input  logic       ext_in,
  input  logic       ext_sel,
  input  logic [2:0] presc,
  input  logic       restart,
  output logic       step
);
  logic [2:0] sync_q;
  logic       ext_rise;
  logic [3:0] div_q;
  logic       div_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_in};
  end

  assign ext_rise = sync_q[1] & ~sync_q[2];
  assign div_hit  = sys_tick && (div_q >= presc_last(presc));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= '0;
    else if (restart)  div_q <= '0;
    else if (sys_tick) div_q <= div_hit ? 4'd0 : div_q + 4'd1;
  end

  assign step = ext_sel ? ext_rise : div_hit;

  AST_EXT_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && step) |=> (!ext_sel || !step)); // R11

  AST_NO_STEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && !sys_tick) |-> !step); // R8
endmodule

// File: rtl/rltmr_count.sv
module rltmr_count #(
  parameter  int CNT_W = 16,
  localparam int NB    = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB-1:0]    byte_we,
  input  logic [7:0]       wbyte,
  input  logic             run,
  input  logic             start,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             uf_evt
);
  logic [CNT_W-1:0] buf_q;
  logic [CNT_W-1:0] buf_nxt;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign buf_nxt[g*8 +: 8] = byte_we[g] ? wbyte : buf_q[g*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else        buf_q <= buf_nxt;
  end

  assign uf_evt = run && step && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (start)              cnt <= buf_q;
    else if (!run && |byte_we)   cnt <= buf_nxt;
    else if (run && step)        cnt <= (cnt == '0) ? buf_q : cnt - 1'b1;
  end

  AST_RELOAD_ON_UF: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> (cnt == $past(buf_q))); // R3

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && !start && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R2

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start && byte_we == '0) |=> $stable(cnt)); // R4

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == $past(buf_q))); // R5

  AST_RUN_WRITE_NO_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !step && !start) |=> $stable(cnt)); // R6
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rltmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_tick,
  input  logic       ext_clk,
  input  logic       irq_en,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  localparam int NB = CNT_W / 8;

  logic             run_q, flag_q, ext_q;
  logic [2:0]       presc_q;
  logic             wr_ctl, start, step, uf_evt;
  logic [NB-1:0]    byte_we;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       hi_byte;

  assign wr_ctl = bus_wr && (bus_addr == ADDR_CTL);
  assign start  = wr_ctl && bus_wdata[BIT_RUN] && !run_q;

  for (genvar g = 0; g < NB; g++) begin : g_we
    assign byte_we[g] = bus_wr && (bus_addr == 2'(g));
  end

  if (NB > 1) begin : g_hi
    assign hi_byte = cnt[8 +: 8];
  end else begin : g_nohi
    assign hi_byte = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      ext_q   <= 1'b0;
      presc_q <= 3'd0;
    end else if (wr_ctl) begin
      run_q   <= bus_wdata[BIT_RUN];
      ext_q   <= bus_wdata[BIT_EXT];
      presc_q <= bus_wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             flag_q <= 1'b0;
    else if (uf_evt)                        flag_q <= 1'b1;
    else if (wr_ctl && !bus_wdata[BIT_FLAG]) flag_q <= 1'b0;
  end

  assign irq = flag_q & irq_en;

  always_comb begin
    case (bus_addr)
      ADDR_LO:  bus_rdata = cnt[7:0];
      ADDR_HI:  bus_rdata = hi_byte;
      ADDR_CTL: bus_rdata = {run_q, flag_q, ext_q, 2'b00, presc_q};
      default:  bus_rdata = 8'h00;
    endcase
  end

  rltmr_clkgen u_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .sys_tick(sys_tick),
    .ext_in  (ext_clk),
    .ext_sel (ext_q),
    .presc   (presc_q),
    .restart (start),
    .step    (step)
  );

  rltmr_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .byte_we(byte_we),
    .wbyte  (bus_wdata),
    .run    (run_q),
    .start  (start),
    .step   (step),
    .cnt    (cnt),
    .uf_evt (uf_evt)
  );

  AST_UF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> flag_q); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_ctl && !bus_wdata[BIT_FLAG])) |=> flag_q); // R9

  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(uf_evt)); // R9
endmodule

// File: tb/reload_timer_test.sv
module reload_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_tick = 1'b0;
  logic       ext_clk = 1'b0;
  logic       irq_en = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int         sel;   // 0..3 bus address, 4 = irq pin
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t exp_q[$];

  always #2 clk = ~clk;

  reload_timer #(.CNT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .ext_clk(ext_clk),
    .irq_en(irq_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Monitor: pops expected items and compares at the falling edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = exp_q.pop_front();
      act = (it.sel == 4) ? {7'b0, irq} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
      end
    end
  end

  // Driver side: all tasks start and end 1 ns after a rising edge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic expect_item(input int sel, input logic [7:0] e, input string tag);
    item_t it;
    if (sel < 4) bus_addr = 2'(sel);
    it.sel = sel; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic ticks(input int n);
    sys_tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 sys_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    expect_item(2, 8'h00, "R1 ctrl reset");
    expect_item(0, 8'h00, "R1 count lo reset");
    expect_item(1, 8'h00, "R1 count hi reset");
    expect_item(4, 8'h00, "R1 irq reset");
    expect_item(3, 8'h00, "R12 unused address");

    // R6 stopped write-through, R7 byte lanes
    wr(0, 8'h34); wr(1, 8'h12);
    expect_item(0, 8'h34, "R6 R7 stopped write lo");
    expect_item(1, 8'h12, "R6 R7 stopped write hi");

    // R5 start, R2 decrement, divide by 1
    wr(2, 8'h80);
    expect_item(2, 8'h80, "R12 ctrl readback run");
    ticks(5);
    expect_item(0, 8'h2F, "R2 count after 5 steps");
    expect_item(1, 8'h12, "R2 hi byte");
    wr(0, 8'h00);
    expect_item(0, 8'h2F, "R6 running write ignored");

    // R8 divide by 4 from start
    wr(2, 8'h00); wr(0, 8'h03); wr(1, 8'h00);
    wr(2, 8'h82);
    ticks(8);
    expect_item(0, 8'h01, "R8 div4 two steps");
    // R4 stop then R8 divide by 16 via 1xx
    wr(2, 8'h02);
    ticks(6);
    expect_item(0, 8'h01, "R4 stopped holds");
    wr(2, 8'h87);
    ticks(16);
    expect_item(0, 8'h02, "R5 R8 div16 one step after reload");

    // R3 R9 underflow
    wr(2, 8'h00); wr(0, 8'h02);
    irq_en = 1'b1;
    wr(2, 8'h80);
    ticks(2);
    expect_item(0, 8'h00, "R2 reached zero");
    expect_item(2, 8'h80, "R9 no flag before underflow");
    expect_item(4, 8'h00, "R9 irq low before underflow");
    ticks(1);
    expect_item(2, 8'hC0, "R9 flag set");
    expect_item(0, 8'h02, "R3 reload");
    expect_item(4, 8'h01, "R9 irq high");
    wr(0, 8'h05);
    expect_item(0, 8'h02, "R6 running write keeps count");
    ticks(3);
    expect_item(0, 8'h05, "R3 new period reloaded");
    irq_en = 1'b0;
    expect_item(4, 8'h00, "R9 irq masked");

    // R10 clear, then set wins over clear
    wr(2, 8'h80);
    expect_item(2, 8'h80, "R10 flag cleared");
    expect_item(0, 8'h05, "R5 no reload while running");
    ticks(5);
    expect_item(0, 8'h00, "R2 at zero again");
    sys_tick = 1'b1;
    wr(2, 8'h80);
    sys_tick = 1'b0;
    expect_item(2, 8'hC0, "R10 set wins over clear");
    expect_item(0, 8'h05, "R3 reload at contested cycle");

    // R11 external clock, sys_tick and prescale ignored
    wr(2, 8'h00); wr(0, 8'h0A);
    wr(2, 8'hA3);
    expect_item(2, 8'hA3, "R12 ctrl readback ext");
    sys_tick = 1'b1;
    for (int i = 0; i < 3; i++) begin
      ext_clk = 1'b1; idle(4);
      ext_clk = 1'b0; idle(4);
    end
    idle(4);
    sys_tick = 1'b0;
    expect_item(0, 8'h07, "R11 three external edges");
    ext_clk = 1'b1; idle(2);
    expect_item(0, 8'h07, "R11 no step before third edge");
    idle(1);
    expect_item(0, 8'h06, "R11 step after sync latency");
    ext_clk = 1'b0; idle(4);

    // R4 stop holds
    wr(2, 8'h00);
    ticks(10);
    expect_item(0, 8'h06, "R4 stop holds count");
    expect_item(2, 8'h00, "R4 ctrl stopped");

    idle(2);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule